// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches the pins of a small I/O port and decides when each pin should request an interrupt. It receives the synchronised pin levels and the port's direction vector from the surrounding port logic. It keeps its own per-pin configuration. Each pin can be level or edge triggered. An edge pin can react to one edge of chosen polarity or to both edges, and a per-pin enable selects which pins feed the shared interrupt line.

Detected events are held in a sticky raw status vector. Software reads the raw status or its enabled subset and acknowledges events by writing ones to a clear location. The combined interrupt output is high while any enabled status bit is set. The register interface (address, write data, write enable, read data) is shared with the rest of the port. Unknown offsets read as zero.

Top module: `gpio_irq_detect`

## Requirements
- R1: During and straight after reset, all configuration and status registers read as zero and `irq` is low.
- R2: The configuration registers can be written and read back at these offsets, with bit i belonging to pin i: trigger mode at 0x404 (1 = level, 0 = edge), dual-edge select at 0x408, polarity at 0x40C, and interrupt enable at 0x410.
- R3: For an input edge pin with its dual-edge bit set, a change of level in either direction sets its raw status bit at the first clock edge that samples the new level.
- R4: For an input edge pin with its dual-edge bit clear, a change sets status only when the new level equals the polarity bit (1 = rising, 0 = falling). The opposite edge has no effect.
- R5: An edge pin whose direction bit is 1 (output) never sets status, whatever its level does.
- R6: A level pin sets status at every clock edge while its level equals the polarity bit, regardless of direction. Its status therefore returns after a clear while the condition lasts.
- R7: Raw status is read at 0x414 and is sticky. A write to 0x41C clears exactly the status bits where the write data has ones, and leaves the others unchanged.
- R8: When a clear and a new detection hit the same bit at the same clock edge, the bit ends up set.
- R9: Reading 0x418 returns raw status ANDed with the enable vector. `irq` is high exactly when that value is non-zero.
- R10: Writes to the status read offsets 0x414 and 0x418 change nothing. Reads of any offset not listed in R2, R7 or R9 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_data | input | PINS | Synchronised pin levels |
| pin_dir | input | PINS | Direction per pin, 1 = output |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | PINS | Register write data |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | PINS | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
A pin level sampled at one clock edge is compared with the level from the previous edge. Any resulting detection appears in raw status after that same edge, so status is due one clock after the pin changes. A register write takes effect at the edge that samples the strobe. Read data and `irq` follow the stored state without further delay. The bench therefore drives pins and strobes on the falling edge and lets exactly one rising edge pass before it compares. It samples read data shortly after setting the address, and it applies each clear on the same edge as the pin step under test, so any status that survives comes only from that step.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_MODE   = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_DUAL   = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_POL    = 12'h40C;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h414;
  localparam logic [ADDR_W-1:0] OFF_MASKED = 12'h418;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 12'h41C;

  // Detection decision for one pin from its previous and current level.
  function automatic logic pin_hit(input logic prev, input logic cur,
                                   input logic is_out, input logic lvl_mode,
                                   input logic dual, input logic pol);
    logic moved;
    logic match;
    moved = (prev ^ cur) & ~is_out;
    match = (cur == pol);
    return lvl_mode ? match : (moved & (dual | match));
  endfunction

  // Sticky update: detections take priority over acknowledge bits.
  function automatic logic sticky_next(input logic cur, input logic ack,
                                       input logic hit);
    return (cur & ~ack) | hit;
  endfunction
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   mode_o,
  output logic [PINS-1:0]   dual_o,
  output logic [PINS-1:0]   pol_o,
  output logic [PINS-1:0]   enable_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o   <= '0;
      dual_o   <= '0;
      pol_o    <= '0;
      enable_o <= '0;
    end else if (we) begin
      if (addr == OFF_MODE)   mode_o   <= wdata;
      if (addr == OFF_DUAL)   dual_o   <= wdata;
      if (addr == OFF_POL)    pol_o    <= wdata;
      if (addr == OFF_ENABLE) enable_o <= wdata;
    end
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic is_out,
  input  logic lvl_mode,
  input  logic dual,
  input  logic pol,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign hit_o = pin_hit(prev_q, cur, is_out, lvl_mode, dual, pol);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] hit_i,
  input  logic [PINS-1:0] ack_i,
  output logic [PINS-1:0] stat_o
);
  for (genvar i = 0; i < PINS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o[i] <= 1'b0;
      else        stat_o[i] <= sticky_next(stat_o[i], ack_i[i], hit_i[i]);
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_data,
  input  logic [PINS-1:0]   pin_dir,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  input  logic              reg_we,
  output logic [PINS-1:0]   reg_rdata,
  output logic              irq
);
  logic [PINS-1:0] mode_q, dual_q, pol_q, enable_q;
  logic [PINS-1:0] hit_vec;
  logic [PINS-1:0] stat_q;
  logic [PINS-1:0] masked;
  logic            ack_pulse;
  logic [PINS-1:0] ack_bits;

  assign ack_pulse = reg_we && (reg_addr == OFF_ACK);
  assign ack_bits  = ack_pulse ? reg_wdata : '0;

  gpio_irq_cfg #(.PINS(PINS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .mode_o   (mode_q),
    .dual_o   (dual_q),
    .pol_o    (pol_q),
    .enable_o (enable_q)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (pin_data[i]),
      .is_out   (pin_dir[i]),
      .lvl_mode (mode_q[i]),
      .dual     (dual_q[i]),
      .pol      (pol_q[i]),
      .hit_o    (hit_vec[i])
    );
  end

  gpio_irq_status #(.PINS(PINS)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit_vec),
    .ack_i  (ack_bits),
    .stat_o (stat_q)
  );

  assign masked = stat_q & enable_q;
  assign irq    = |masked;

  always_comb begin
    case (reg_addr)
      OFF_MODE:   reg_rdata = mode_q;
      OFF_DUAL:   reg_rdata = dual_q;
      OFF_POL:    reg_rdata = pol_q;
      OFF_ENABLE: reg_rdata = enable_q;
      OFF_RAW:    reg_rdata = stat_q;
      OFF_MASKED: reg_rdata = masked;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] pin_data,
  input logic [PINS-1:0] pin_dir,
  input logic            irq,
  input logic [PINS-1:0] hit_vec,
  input logic [PINS-1:0] stat_q,
  input logic [PINS-1:0] mode_q,
  input logic [PINS-1:0] dual_q,
  input logic [PINS-1:0] pol_q,
  input logic [PINS-1:0] ack_bits
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!irq && stat_q == '0)
        else $error("R1: irq or status active during reset");
    end
  end

  a_r4_polarity_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(mode_q) & ~$past(dual_q)
      & ($past(pin_data) ^ $past(pol_q))) == '0))
    else $error("R4: single-edge status set on wrong level");

  a_r5_no_output_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(mode_q) & $past(pin_dir)) == '0))
    else $error("R5: edge status set on output pin");

  a_r6_level_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode_q & ~(pin_data ^ pol_q)) & ~stat_q) == '0))
    else $error("R6: active level did not hold status");

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat_q) & ~stat_q & ~$past(ack_bits)) == '0))
    else $error("R7: status dropped without acknowledge");

  a_r8_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(hit_vec) & ~stat_q) == '0))
    else $error("R8: detection lost");
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.PINS(PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_data (pin_data),
  .pin_dir  (pin_dir),
  .irq      (irq),
  .hit_vec  (hit_vec),
  .stat_q   (stat_q),
  .mode_q   (mode_q),
  .dual_q   (dual_q),
  .pol_q    (pol_q),
  .ack_bits (ack_bits)
);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  localparam int CLK_P = 10;
  localparam int PINS  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PINS-1:0] pin_data = '0;
  logic [PINS-1:0] pin_dir = '0;
  logic [11:0]     reg_addr = '0;
  logic [PINS-1:0] reg_wdata = '0;
  logic            reg_we = 1'b0;
  logic [PINS-1:0] reg_rdata;
  logic            irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_detect #(.PINS(PINS)) i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .pin_dir(pin_dir),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [PINS-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [PINS-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [PINS-1:0] model(
      input logic [PINS-1:0] a, input logic [PINS-1:0] b, input logic [PINS-1:0] dir,
      input logic [PINS-1:0] md, input logic [PINS-1:0] du, input logic [PINS-1:0] pl);
    logic [PINS-1:0] rise, fall, lvl, edg;
    rise = ~a & b;
    fall = a & ~b;
    lvl  = md & ~(b ^ pl);
    edg  = ~md & ~dir & ((du & (rise | fall)) | (~du & ((pl & rise) | (~pl & fall))));
    return lvl | edg;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [PINS-1:0] v;
    logic [PINS-1:0] pats [4];
    logic [PINS-1:0] dirs [3];
    logic [PINS-1:0] md, du, pl, m, e;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'h0F;
    dirs[0] = 8'h00; dirs[1] = 8'hFF; dirs[2] = 8'h5A;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", irq, 0);
    rd(12'h404, v); check("R1 mode", v, 0);
    rd(12'h408, v); check("R1 dual", v, 0);
    rd(12'h40C, v); check("R1 pol", v, 0);
    rd(12'h410, v); check("R1 enable", v, 0);
    rd(12'h414, v); check("R1 raw", v, 0);
    rd(12'h418, v); check("R1 masked", v, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h414, v); check("R1 raw after release", v, 0);
    check("R1 irq after release", irq, 0);

    // Sweep: pin i takes mode=i[2], dual=i[1], pol=i[0]; second pass inverts.
    for (int c = 0; c < 2; c++) begin
      md = (c == 0) ? 8'hF0 : 8'h0F;
      du = (c == 0) ? 8'hCC : 8'h33;
      pl = (c == 0) ? 8'hAA : 8'h55;
      wr(12'h404, md); wr(12'h408, du); wr(12'h40C, pl);
      rd(12'h404, v); check("R2 mode readback", v, md);
      rd(12'h408, v); check("R2 dual readback", v, du);
      rd(12'h40C, v); check("R2 pol readback", v, pl);
      for (int d = 0; d < 3; d++) begin
        for (int ia = 0; ia < 4; ia++) begin
          for (int ib = 0; ib < 4; ib++) begin
            m = 8'hFF ^ 8'((c * 48 + d * 16 + ia * 4 + ib) * 37);
            pin_dir  = dirs[d];
            pin_data = pats[ia];
            wr(12'h410, m);
            // Pin step and full acknowledge on the same edge (R8).
            pin_data = pats[ib];
            reg_addr = 12'h41C; reg_wdata = '1; reg_we = 1'b1;
            @(negedge clk);
            reg_we = 1'b0;
            e = model(pats[ia], pats[ib], dirs[d], md, du, pl);
            rd(12'h414, v); check("R3 R4 R5 R6 R8 raw after step", v, e);
            rd(12'h418, v); check("R9 masked after step", v, e & m);
            check("R9 irq after step", irq, |(e & m));
            @(negedge clk);
          end
        end
      end
    end

    // R7 / R10: partial acknowledge, ignored writes, unmapped reads.
    wr(12'h404, 8'h00); wr(12'h408, 8'hFF); wr(12'h410, 8'h00);
    pin_dir = 8'h00; pin_data = 8'h00;
    wr(12'h41C, 8'hFF);
    @(negedge clk);
    pin_data = 8'hFF;
    @(negedge clk);
    rd(12'h414, v); check("R3 dual edge all pins", v, 8'hFF);
    wr(12'h41C, 8'h0F);
    rd(12'h414, v); check("R7 partial clear", v, 8'hF0);
    wr(12'h414, 8'hFF);
    wr(12'h418, 8'h0F);
    rd(12'h414, v); check("R10 raw unchanged by status writes", v, 8'hF0);
    check("R10 irq still low", irq, 0);
    rd(12'h400, v); check("R10 unmapped read", v, 0);
    rd(12'h420, v); check("R10 unmapped read high", v, 0);
    wr(12'h410, 8'h30);
    rd(12'h418, v); check("R9 masked subset", v, 8'h30);
    check("R9 irq high", irq, 1);
    wr(12'h41C, 8'h30);
    check("R9 irq low after clear", irq, 0);
    rd(12'h414, v); check("R7 untouched bits kept", v, 8'hC0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule